// File: doc/BRIEF.md
# Banked Physical Address Decoder

This block turns a 32-bit physical address into a target select and a wait-state count for the memory controller sitting behind a CPU. The lowest megabyte is split into fixed windows (main RAM, a graphics page holding plane memory, sprite memory and font ROM, a dictionary window and a ROM/RAM shadow window). Above that sit extended RAM of configurable size, high video apertures, two card slots, a cluster of read-only stores with a backup RAM and a PCM device, and the boot ROM at the very top.

Two run-time control bits re-bank the low megabyte. One places the dictionary device in the 0xD0000 window. The other places the system ROM in the 0xF8000 window. Two programmable wait registers, one for ordinary memory and one for video memory, supply the wait count. The decode is combinational from the address and the registered control state, so the select, the write permission and the wait count all appear in the same cycle as the address. Unmapped addresses raise a no-target flag. The bus then returns 0xFF on reads and drops writes.

Top module: `mmap_decoder`

## Requirements
- R1: Addresses 0x00000000 to 0x000BFFFF select main RAM (code 1), writable, with the memory wait value.
- R2: In page 0x000Cxxxx, 0xC0000–0xC7FFF selects plane memory (code 2), 0xC8000–0xC9FFF selects sprite memory (code 3) and 0xCC000–0xCFFFF selects main RAM. Every address in the page uses the video wait value.
- R3: 0xCA000–0xCBFFF selects font ROM (code 4), and write permission is low there. Font ROM, OS ROM, dictionary ROM and system ROM are never writable.
- R4: With the dictionary bit clear, 0xD0000–0xEFFFF is main RAM. With it set, 0xD0000–0xD9FFF selects the dictionary window (code 5, writable, memory wait) and 0xDA000–0xEFFFF has no target.
- R5: 0xF0000–0xF7FFF is main RAM. With the ROM bit set, 0xF8000–0xFFFFF selects system ROM (code 6), not writable. With it clear, that range is writable main RAM. Both cases use the memory wait value.
- R6: Extended RAM (code 7, writable, memory wait) covers 0x00100000 up to 0x00100000 plus the size input ANDed with 0x3FF00000, exclusive. A size below one megabyte maps nothing.
- R7: 0x80000000–0x8007FFFF and 0x80100000–0x8017FFFF select video memory (code 8), and 0x81000000–0x8101FFFF selects sprite memory (code 3). All three are writable and use the video wait value.
- R8: 0xC0xxxxxx and 0xC1xxxxxx select card slots A and B (codes 9, 10). 0xC2000000–0xC207FFFF selects OS ROM (11), 0xC2080000–0xC20FFFFF dictionary ROM (12), 0xC2100000–0xC213FFFF font ROM (4), 0xC2140000–0xC2141FFF backup RAM (13, writable), 0xC2200000–0xC2200FFF PCM (14, writable), and 0xFFFC0000–0xFFFFFFFF system ROM (6). All use the memory wait value.
- R9: Any other address gives code 0 with the no-target flag high, write permission low and a wait count of 0.
- R10: After reset the dictionary bit is clear, the ROM bit is set, the memory wait is 3 and the video wait is 6.
- R11: A bank or wait write is taken at the clock edge where its enable is high and affects the decode from the next cycle on. With the enable low the setting holds.
- R12: The one-hot output has exactly one bit set, and that bit is the one at the index equal to the target code. Bit 0 means no target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Physical address to decode |
| ext_size | input | 32 | Extended RAM size in bytes, whole megabytes used |
| cfg_we | input | 1 | Load both bank bits |
| cfg_dict_sel | input | 1 | New dictionary-window bit |
| cfg_rom_sel | input | 1 | New ROM-shadow bit |
| wait_we | input | 1 | Load both wait registers |
| wait_mem_val | input | WAIT_W | New memory wait value |
| wait_vram_val | input | WAIT_W | New video wait value |
| tgt_code | output | 4 | Encoded target |
| tgt_onehot | output | 15 | One-hot target, index equals code |
| no_tgt | output | 1 | Address maps to nothing |
| wr_allow | output | 1 | Writes may reach the target |
| wait_cnt | output | WAIT_W | Wait states for this access |

## Verification
The address pattern walks both edges of every window, plus the first address past each high region, so an off-by-one boundary shows up as a wrong code. The low megabyte is swept again under each combination of the two bank bits, which separates bank-dependent decoding from fixed decoding. The wait registers are then reloaded with distinct values, which reveals any region fed from the wrong register. Changing the extended RAM size, including one that is not a whole number of megabytes and one of zero, tests the size masking. Each of these cycles is compared against a behavioural model of the map.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int TGT_W   = 4;
    localparam int NUM_TGT = 15;

    typedef enum logic [TGT_W-1:0] {
        TGT_NONE      = 4'd0,
        TGT_MAIN_RAM  = 4'd1,
        TGT_PLANE     = 4'd2,
        TGT_SPRITE    = 4'd3,
        TGT_FONT      = 4'd4,
        TGT_DICT_WIN  = 4'd5,
        TGT_SYS_ROM   = 4'd6,
        TGT_EXT_RAM   = 4'd7,
        TGT_VRAM      = 4'd8,
        TGT_CARD_A    = 4'd9,
        TGT_CARD_B    = 4'd10,
        TGT_OS_ROM    = 4'd11,
        TGT_DICT_ROM  = 4'd12,
        TGT_DICT_BKUP = 4'd13,
        TGT_PCM       = 4'd14
    } tgt_e;

    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_MEM  = 2'd1,
        WSRC_VRAM = 2'd2
    } wsrc_e;

    typedef struct packed {
        tgt_e  tgt;
        logic  wr_ok;
        wsrc_e wsrc;
    } dec_t;

    // low megabyte window limits (exclusive upper bounds)
    localparam logic [19:0] LO_RAM_END    = 20'hC0000;
    localparam logic [19:0] LO_PLANE_END  = 20'hC8000;
    localparam logic [19:0] LO_SPRITE_END = 20'hCA000;
    localparam logic [19:0] LO_FONT_END   = 20'hCC000;
    localparam logic [19:0] LO_CPAGE_END  = 20'hD0000;
    localparam logic [19:0] LO_DICT_END   = 20'hDA000;
    localparam logic [19:0] LO_DWIN_END   = 20'hF0000;
    localparam logic [19:0] LO_SHADOW_BEG = 20'hF8000;

    localparam logic [31:0] EXT_BASE = 32'h0010_0000;

endpackage

// File: rtl/mmap_ctl_regs.sv
module mmap_ctl_regs #(
    parameter int WAIT_W        = 4,
    parameter int MEM_WAIT_RST  = 3,
    parameter int VRAM_WAIT_RST = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_dict_sel,
    input  logic              cfg_rom_sel,
    input  logic              wait_we,
    input  logic [WAIT_W-1:0] wait_mem_val,
    input  logic [WAIT_W-1:0] wait_vram_val,
    output logic              dict_sel,
    output logic              rom_sel,
    output logic [WAIT_W-1:0] mem_wait,
    output logic [WAIT_W-1:0] vram_wait
);

    typedef struct packed {
        logic              dict;
        logic              rom;
        logic [WAIT_W-1:0] mwait;
        logic [WAIT_W-1:0] vwait;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we) begin
            ctl_d.dict = cfg_dict_sel;
            ctl_d.rom  = cfg_rom_sel;
        end
        if (wait_we) begin
            ctl_d.mwait = wait_mem_val;
            ctl_d.vwait = wait_vram_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.dict  <= 1'b0;
            ctl_q.rom   <= 1'b1;
            ctl_q.mwait <= WAIT_W'(MEM_WAIT_RST);
            ctl_q.vwait <= WAIT_W'(VRAM_WAIT_RST);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dict_sel  = ctl_q.dict;
    assign rom_sel   = ctl_q.rom;
    assign mem_wait  = ctl_q.mwait;
    assign vram_wait = ctl_q.vwait;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(dict_sel) && $stable(rom_sel))); // R11
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (dict_sel == $past(cfg_dict_sel) && rom_sel == $past(cfg_rom_sel))); // R11
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_we |=> ($stable(mem_wait) && $stable(vram_wait))); // R11

endmodule

// File: rtl/mmap_low_dec.sv
module mmap_low_dec
    import mmap_pkg::*;
(
    input  logic [19:0] lo_addr,
    input  logic        dict_sel,
    input  logic        rom_sel,
    output dec_t        dec
);

    always_comb begin
        dec = '{tgt: TGT_NONE, wr_ok: 1'b0, wsrc: WSRC_NONE};
        if (lo_addr < LO_RAM_END) begin
            dec = '{tgt: TGT_MAIN_RAM, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (lo_addr < LO_CPAGE_END) begin
            // graphics page: every slot paced by the video wait
            if (lo_addr < LO_PLANE_END)
                dec = '{tgt: TGT_PLANE, wr_ok: 1'b1, wsrc: WSRC_VRAM};
            else if (lo_addr < LO_SPRITE_END)
                dec = '{tgt: TGT_SPRITE, wr_ok: 1'b1, wsrc: WSRC_VRAM};
            else if (lo_addr < LO_FONT_END)
                dec = '{tgt: TGT_FONT, wr_ok: 1'b0, wsrc: WSRC_VRAM};
            else
                dec = '{tgt: TGT_MAIN_RAM, wr_ok: 1'b1, wsrc: WSRC_VRAM};
        end else if (lo_addr < LO_DWIN_END) begin
            if (!dict_sel)
                dec = '{tgt: TGT_MAIN_RAM, wr_ok: 1'b1, wsrc: WSRC_MEM};
            else if (lo_addr < LO_DICT_END)
                dec = '{tgt: TGT_DICT_WIN, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (lo_addr < LO_SHADOW_BEG) begin
            dec = '{tgt: TGT_MAIN_RAM, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (rom_sel) begin
            dec = '{tgt: TGT_SYS_ROM, wr_ok: 1'b0, wsrc: WSRC_MEM};
        end else begin
            dec = '{tgt: TGT_MAIN_RAM, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end
    end

endmodule

// File: rtl/mmap_high_dec.sv
module mmap_high_dec
    import mmap_pkg::*;
#(
    parameter logic [31:0] EXT_MASK = 32'h3FF0_0000
) (
    input  logic [31:0] addr,
    input  logic [31:0] ext_size,
    output dec_t        dec
);

    logic [32:0] ext_end;
    logic        in_ext;

    assign ext_end = {1'b0, EXT_BASE} + {1'b0, ext_size & EXT_MASK};
    assign in_ext  = (addr >= EXT_BASE) && ({1'b0, addr} < ext_end);

    always_comb begin
        dec = '{tgt: TGT_NONE, wr_ok: 1'b0, wsrc: WSRC_NONE};
        if (in_ext) begin
            dec = '{tgt: TGT_EXT_RAM, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (addr[31:19] == 13'h1000 || addr[31:19] == 13'h1002) begin
            dec = '{tgt: TGT_VRAM, wr_ok: 1'b1, wsrc: WSRC_VRAM};
        end else if (addr[31:17] == 15'h4080) begin
            dec = '{tgt: TGT_SPRITE, wr_ok: 1'b1, wsrc: WSRC_VRAM};
        end else if (addr[31:24] == 8'hC0) begin
            dec = '{tgt: TGT_CARD_A, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (addr[31:24] == 8'hC1) begin
            dec = '{tgt: TGT_CARD_B, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (addr[31:20] == 12'hC20) begin
            if (addr[19] == 1'b0)
                dec = '{tgt: TGT_OS_ROM, wr_ok: 1'b0, wsrc: WSRC_MEM};
            else
                dec = '{tgt: TGT_DICT_ROM, wr_ok: 1'b0, wsrc: WSRC_MEM};
        end else if (addr[31:18] == 14'h3084) begin
            dec = '{tgt: TGT_FONT, wr_ok: 1'b0, wsrc: WSRC_MEM};
        end else if (addr[31:13] == 19'h610A0) begin
            dec = '{tgt: TGT_DICT_BKUP, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (addr[31:12] == 20'hC2200) begin
            dec = '{tgt: TGT_PCM, wr_ok: 1'b1, wsrc: WSRC_MEM};
        end else if (addr[31:18] == 14'h3FFF) begin
            dec = '{tgt: TGT_SYS_ROM, wr_ok: 1'b0, wsrc: WSRC_MEM};
        end
    end

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int          WAIT_W        = 4,
    parameter int          MEM_WAIT_RST  = 3,
    parameter int          VRAM_WAIT_RST = 6,
    parameter logic [31:0] EXT_MASK      = 32'h3FF0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        addr,
    input  logic [31:0]        ext_size,
    input  logic               cfg_we,
    input  logic               cfg_dict_sel,
    input  logic               cfg_rom_sel,
    input  logic               wait_we,
    input  logic [WAIT_W-1:0]  wait_mem_val,
    input  logic [WAIT_W-1:0]  wait_vram_val,
    output logic [TGT_W-1:0]   tgt_code,
    output logic [NUM_TGT-1:0] tgt_onehot,
    output logic               no_tgt,
    output logic               wr_allow,
    output logic [WAIT_W-1:0]  wait_cnt
);

    logic              dict_sel, rom_sel;
    logic [WAIT_W-1:0] mem_wait, vram_wait;
    dec_t              lo_dec, hi_dec, dec;

    mmap_ctl_regs #(
        .WAIT_W        (WAIT_W),
        .MEM_WAIT_RST  (MEM_WAIT_RST),
        .VRAM_WAIT_RST (VRAM_WAIT_RST)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_dict_sel  (cfg_dict_sel),
        .cfg_rom_sel   (cfg_rom_sel),
        .wait_we       (wait_we),
        .wait_mem_val  (wait_mem_val),
        .wait_vram_val (wait_vram_val),
        .dict_sel      (dict_sel),
        .rom_sel       (rom_sel),
        .mem_wait      (mem_wait),
        .vram_wait     (vram_wait)
    );

    mmap_low_dec u_lo (
        .lo_addr  (addr[19:0]),
        .dict_sel (dict_sel),
        .rom_sel  (rom_sel),
        .dec      (lo_dec)
    );

    mmap_high_dec #(.EXT_MASK(EXT_MASK)) u_hi (
        .addr     (addr),
        .ext_size (ext_size),
        .dec      (hi_dec)
    );

    assign dec = (addr[31:20] == 12'h000) ? lo_dec : hi_dec;

    always_comb begin
        unique case (dec.wsrc)
            WSRC_MEM:  wait_cnt = mem_wait;
            WSRC_VRAM: wait_cnt = vram_wait;
            default:   wait_cnt = '0;
        endcase
    end

    assign tgt_code = dec.tgt;
    assign wr_allow = dec.wr_ok;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_onehot
        assign tgt_onehot[g] = (dec.tgt == tgt_e'(TGT_W'(g)));
    end

    assign no_tgt = tgt_onehot[0];

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgt_onehot) == 1); // R12
    AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_onehot[TGT_FONT] || tgt_onehot[TGT_OS_ROM] ||
         tgt_onehot[TGT_DICT_ROM] || tgt_onehot[TGT_SYS_ROM]) |-> !wr_allow); // R3
    AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        no_tgt |-> (!wr_allow && wait_cnt == '0)); // R9
    AST_CPAGE_VWAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[31:16] == 16'h000C) |-> (wait_cnt == vram_wait)); // R2
    AST_SHADOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && addr[31:15] == 17'h0001F) |-> (tgt_onehot[TGT_SYS_ROM] && !wr_allow)); // R5

endmodule

// File: tb/mmap_decoder_bench.sv
module mmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] ext_size = 32'h0030_0ABC;
    logic        cfg_we = 1'b0, cfg_dict_sel = 1'b0, cfg_rom_sel = 1'b0;
    logic        wait_we = 1'b0;
    logic [3:0]  wait_mem_val = '0, wait_vram_val = '0;
    logic [3:0]  tgt_code;
    logic [14:0] tgt_onehot;
    logic        no_tgt, wr_allow;
    logic [3:0]  wait_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string note = "";

    // behavioural model state
    bit m_dict = 0, m_rom = 1;
    int m_mw = 3, m_vw = 6;

    always #2 clk = ~clk;

    mmap_decoder u_mmap_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ext_size(ext_size),
        .cfg_we(cfg_we), .cfg_dict_sel(cfg_dict_sel), .cfg_rom_sel(cfg_rom_sel),
        .wait_we(wait_we), .wait_mem_val(wait_mem_val), .wait_vram_val(wait_vram_val),
        .tgt_code(tgt_code), .tgt_onehot(tgt_onehot), .no_tgt(no_tgt),
        .wr_allow(wr_allow), .wait_cnt(wait_cnt)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dict = 0; m_rom = 1; m_mw = 3; m_vw = 6;
        end else begin
            if (cfg_we) begin m_dict = cfg_dict_sel; m_rom = cfg_rom_sel; end
            if (wait_we) begin m_mw = wait_mem_val; m_vw = wait_vram_val; end
        end
    end

    function automatic void model(input longint a, output int code, output bit w,
                                  output int wt, output string req);
        longint ext_top = 64'h10_0000 + (longint'(ext_size) & 64'h3FF0_0000);
        code = 0; w = 0; wt = 0; req = "R9";
        if (a <= 64'hBFFFF) begin code = 1; w = 1; wt = m_mw; req = "R1"; end
        else if (a <= 64'hCFFFF) begin
            wt = m_vw; w = 1; req = "R2";
            if (a <= 64'hC7FFF) code = 2;
            else if (a <= 64'hC9FFF) code = 3;
            else if (a <= 64'hCBFFF) begin code = 4; w = 0; req = "R3"; end
            else code = 1;
        end
        else if (a <= 64'hEFFFF) begin
            req = "R4";
            if (!m_dict) begin code = 1; w = 1; wt = m_mw; end
            else if (a <= 64'hD9FFF) begin code = 5; w = 1; wt = m_mw; end
        end
        else if (a <= 64'hFFFFF) begin
            req = "R5"; wt = m_mw;
            if (a >= 64'hF8000 && m_rom) begin code = 6; w = 0; end
            else begin code = 1; w = 1; end
        end
        else if (a < ext_top) begin code = 7; w = 1; wt = m_mw; req = "R6"; end
        else if ((a >= 64'h8000_0000 && a <= 64'h8007_FFFF) ||
                 (a >= 64'h8010_0000 && a <= 64'h8017_FFFF)) begin code = 8; w = 1; wt = m_vw; req = "R7"; end
        else if (a >= 64'h8100_0000 && a <= 64'h8101_FFFF) begin code = 3; w = 1; wt = m_vw; req = "R7"; end
        else begin
            wt = m_mw; req = "R8";
            if (a >= 64'hC000_0000 && a <= 64'hC0FF_FFFF) begin code = 9; w = 1; end
            else if (a >= 64'hC100_0000 && a <= 64'hC1FF_FFFF) begin code = 10; w = 1; end
            else if (a >= 64'hC200_0000 && a <= 64'hC207_FFFF) code = 11;
            else if (a >= 64'hC208_0000 && a <= 64'hC20F_FFFF) code = 12;
            else if (a >= 64'hC210_0000 && a <= 64'hC213_FFFF) code = 4;
            else if (a >= 64'hC214_0000 && a <= 64'hC214_1FFF) begin code = 13; w = 1; end
            else if (a >= 64'hC220_0000 && a <= 64'hC220_0FFF) begin code = 14; w = 1; end
            else if (a >= 64'hFFFC_0000) code = 6;
            else begin wt = 0; req = "R9"; end
        end
        if (code == 0) req = (req == "R4") ? "R4" : (req == "R6" ? "R6" : "R9");
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s addr=%h actual=%0h expected=%0h", req, what, addr, act, exp);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ec, ewt; bit ew; string rq;
            model(longint'(addr), ec, ew, ewt, rq);
            rq = {rq, note};
            chk(tgt_code == 4'(ec), rq, "code", tgt_code, ec);
            chk(wr_allow == ew, rq, "wr_allow", wr_allow, ew);
            chk(wait_cnt == 4'(ewt), rq, "wait", wait_cnt, ewt);
            chk(no_tgt == (ec == 0), "R9", "no_tgt", no_tgt, ec == 0);
            chk(tgt_onehot == (15'd1 << ec), "R12", "onehot", tgt_onehot, 15'd1 << ec);
        end
    end

    task automatic step(input logic [31:0] a);
        @(posedge clk); #1 addr = a;
    endtask

    task automatic set_bank(input bit d, input bit r);
        @(posedge clk); #1 cfg_we = 1; cfg_dict_sel = d; cfg_rom_sel = r;
        @(posedge clk); #1 cfg_we = 0;
    endtask

    logic [31:0] sweep [44] = '{
        32'h0, 32'hBFFFF, 32'hC0000, 32'hC7FFF, 32'hC8000, 32'hC9FFF, 32'hCA000,
        32'hCBFFF, 32'hCC000, 32'hCFFFF, 32'hD0000, 32'hEFFFF, 32'hF0000, 32'hF7FFF,
        32'hF8000, 32'hFFFFF, 32'h100000, 32'h3FFFFF, 32'h400000, 32'h7FFFFFFF,
        32'h80000000, 32'h8007FFFF, 32'h80080000, 32'h80100000, 32'h8017FFFF,
        32'h81000000, 32'h8101FFFF, 32'h81020000, 32'hC0000000, 32'hC1FFFFFF,
        32'hC2000000, 32'hC207FFFF, 32'hC2080000, 32'hC2100000, 32'hC213FFFF,
        32'hC2140000, 32'hC2141FFF, 32'hC2142000, 32'hC2200000, 32'hC2200FFF,
        32'hC2201000, 32'hFFFBFFFF, 32'hFFFC0000, 32'hFFFFFFFF };

    logic [31:0] lowset [8] = '{
        32'hD0000, 32'hD9FFF, 32'hDA000, 32'hEFFFF,
        32'hF7FFF, 32'hF8000, 32'hFFFFF, 32'hCA000 };

    initial begin
        // reset state, R10
        addr = 32'hF8000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(tgt_code == 4'd6, "R10", "rom shadow at reset", tgt_code, 6);
        chk(wait_cnt == 4'd3, "R10", "mem wait at reset", wait_cnt, 3);
        addr = 32'hD0000;
        @(negedge clk);
        chk(tgt_code == 4'd1, "R10", "dict window at reset", tgt_code, 1);
        addr = 32'hC0000;
        @(negedge clk);
        chk(wait_cnt == 4'd6, "R10", "vram wait at reset", wait_cnt, 6);
        @(posedge clk); #1 rst_n = 1;

        foreach (sweep[i]) step(sweep[i]);

        // R11: bank write seen only after the edge
        step(32'hD0000);
        @(posedge clk); #1 cfg_we = 1; cfg_dict_sel = 1; cfg_rom_sel = 0;
        @(negedge clk);
        chk(tgt_code == 4'd1, "R11", "before load", tgt_code, 1);
        @(posedge clk); #1 cfg_we = 0;
        @(negedge clk);
        chk(tgt_code == 4'd5, "R11", "after load", tgt_code, 5);

        foreach (lowset[i]) step(lowset[i]);
        set_bank(1, 1);
        foreach (lowset[i]) step(lowset[i]);
        set_bank(0, 0);
        foreach (lowset[i]) step(lowset[i]);

        // R11: wait reload, held while enable low
        @(posedge clk); #1 wait_we = 1; wait_mem_val = 4'd1; wait_vram_val = 4'd9; note = " R11";
        @(posedge clk); #1 wait_we = 0; wait_mem_val = 4'd7; wait_vram_val = 4'd2;
        foreach (sweep[i]) step(sweep[i]);
        note = "";

        // R6: size changes
        ext_size = 32'h0000_0000;
        step(32'h100000);
        step(32'h3FFFFF);
        ext_size = 32'h3FFF_FFFF;
        step(32'h3FFFFFFF);
        step(32'h40000000);
        step(32'h40100000);

        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule